// File: doc/BRIEF.md
# Sigma-Delta Bitstream Capture Front End

This block sits between the clock and data pins of one external sigma-delta modulator and the decimation logic of the chip. It brings both pins into the system clock domain. Each pin can optionally pass through its own two-flop synchronizer. The block then picks out the qualifying modulator-clock edges, or the Manchester mid-cell transitions, and delivers one captured data bit per qualifying event on a valid/ready output.

A 3-bit mode input selects the capture rule: rising edge, falling edge, both edges, every second rising or falling edge, or Manchester decoding of the data line with a programmable spacing threshold. The block also tracks the largest spacing between monitored edges as an 8-bit period value. A watchdog raises a sticky failure flag when the monitored line stops toggling. The flag has an interrupt enable and a write-1-to-clear pulse.

The output is a sample stream. `out_valid` rises one cycle after a qualifying event and stays high until `out_ready` is seen. The modulator cannot be stalled. If a new sample arrives before the held one is taken, the new sample replaces the old one.

Top module: `bitstream_capture`

## Requirements
- R1: With `mode` 000 a sample is taken at each rising edge of the modulator clock, with 011 at each falling edge, and with 001 at both edges. The captured bit is the data pin level at the cycle the edge is detected.
- R2: With `mode` 100 a sample is taken at every second rising edge, and with 101 at every second falling edge. The first qualifying edge after `chan_en` rises is always taken.
- R3: With `mode` 010 the data line is Manchester decoded. A data transition is accepted when more than `manch_thr` cycles have passed since the previously accepted transition, or when it is the first transition after enable. The new line level becomes the sample bit. All other transitions are ignored.
- R4: With `mode` 110 or 111 no sample is produced.
- R5: `sync_clk_sel` and `sync_dat_sel` each insert a two-flop synchronizer on their own pin. With either setting, a stable pattern yields the same sample sequence.
- R6: `period` holds the largest spacing, in system cycles, between consecutive monitored edges since enable. Monitored edges are both clock edges in modes other than 010, and data transitions in mode 010. The first edge after enable sets no spacing.
- R7: When `wdog_limit` is non-zero and at least `wdog_limit` cycles pass with no monitored edge while enabled, `fail_flag` is set. A zero limit disables the watchdog.
- R8: `fail_flag` is sticky and is cleared by a one-cycle `fail_clr` pulse. A halt condition in the same cycle wins over the clear. `fail_irq` is `fail_flag` gated by `fail_ie`.
- R9: While `chan_en` is low no sample is produced. `period` reads 0, and the edge history, toggle and watchdog count are reset.
- R10: `out_valid` stays high with `out_bit` unchanged while `out_ready` is low and no new sample arrives. A new sample overwrites an unaccepted one.
- R11: After reset `out_valid`, `period` and `fail_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| mode | input | 3 | Capture mode code |
| sync_clk_sel | input | 1 | Route the clock pin through the synchronizer |
| sync_dat_sel | input | 1 | Route the data pin through the synchronizer |
| manch_thr | input | 7 | Manchester acceptance spacing threshold |
| wdog_limit | input | 8 | Halt watchdog limit in cycles (0 disables) |
| fail_ie | input | 1 | Failure interrupt enable |
| fail_clr | input | 1 | Write-1-to-clear pulse for the failure flag |
| mod_clk | input | 1 | Modulator clock pin |
| mod_dat | input | 1 | Modulator data pin |
| out_ready | input | 1 | Downstream accepts the held sample |
| out_valid | output | 1 | A captured sample is held |
| out_bit | output | 1 | Captured sample bit |
| period | output | 8 | Largest measured edge spacing |
| fail_flag | output | 1 | Sticky modulator-halt flag |
| fail_irq | output | 1 | Failure interrupt request |

## Verification
The hardest states to reach are the Manchester lock and the watchdog clear race. For the lock, the decoder must first accept a true mid-cell transition and then reject the boundary transitions between equal bits. The stimulus starts the line idle at the inverse of the first bit, so the first accepted transition is a mid-cell one, and the pattern mixes runs of equal and alternating bits. For the race, the bench halts the clock past the limit and pulses the clear while the halt is still present, so the flag must stay set. It then restarts the clock and clears again.

// File: rtl/sdcap_pkg.sv
package sdcap_pkg;
  typedef enum logic [2:0] {
    CAP_RISE     = 3'b000,
    CAP_BOTH     = 3'b001,
    CAP_MANCH    = 3'b010,
    CAP_FALL     = 3'b011,
    CAP_ALT_RISE = 3'b100,
    CAP_ALT_FALL = 3'b101
  } cap_mode_e;
endpackage

// File: rtl/sdcap_pin_sync.sv
module sdcap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic use_sync,
  output logic pin
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff <= '0;
    end else begin
      ff[0] <= raw;
      for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
    end
  end

  assign pin = use_sync ? ff[STAGES-1] : raw;
endmodule

// File: rtl/sdcap_edge_qual.sv
module sdcap_edge_qual
  import sdcap_pkg::*;
#(
  parameter int GAP_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       mode,
  input  logic             clk_s,
  input  logic             dat_s,
  input  logic [GAP_W-1:0] manch_thr,
  output logic             strobe,
  output logic             bit_o,
  output logic             any_edge
);
  localparam logic [CNT_W-1:0] GAP_MAX = '1;

  logic             clk_q, dat_q, alt_tog;
  logic [CNT_W-1:0] gap;
  logic             rise, fall, dtr, manch_ok, hit;
  cap_mode_e        md;

  assign md       = cap_mode_e'(mode);
  assign rise     = clk_s & ~clk_q;
  assign fall     = ~clk_s & clk_q;
  assign dtr      = dat_s ^ dat_q;
  assign manch_ok = dtr && (gap >= CNT_W'(manch_thr));

  always_comb begin
    case (md)
      CAP_RISE:     hit = rise;
      CAP_BOTH:     hit = rise | fall;
      CAP_FALL:     hit = fall;
      CAP_ALT_RISE: hit = rise & ~alt_tog;
      CAP_ALT_FALL: hit = fall & ~alt_tog;
      CAP_MANCH:    hit = manch_ok;
      default:      hit = 1'b0;
    endcase
  end

  assign strobe   = en & hit;
  assign bit_o    = dat_s;
  assign any_edge = en & ((md == CAP_MANCH) ? dtr : (rise | fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= 1'b0;
      dat_q   <= 1'b0;
      alt_tog <= 1'b0;
      gap     <= GAP_MAX;
    end else begin
      clk_q <= clk_s;
      dat_q <= dat_s;
      if (!en) begin
        alt_tog <= 1'b0;
        gap     <= GAP_MAX;
      end else begin
        if ((md == CAP_ALT_RISE && rise) || (md == CAP_ALT_FALL && fall))
          alt_tog <= ~alt_tog;
        if (md == CAP_MANCH && manch_ok) gap <= '0;
        else if (gap != GAP_MAX)         gap <= gap + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdcap_spacing_mon.sv
module sdcap_spacing_mon #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] wdog_lim,
  output logic [CNT_W-1:0] period,
  output logic             halt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, spacing;
  logic             seen;

  assign spacing = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign halt    = en && (wdog_lim != '0) && !edge_i && (cnt >= wdog_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      seen   <= 1'b0;
      period <= '0;
    end else if (!en) begin
      cnt    <= '0;
      seen   <= 1'b0;
      period <= '0;
    end else if (edge_i) begin
      cnt  <= '0;
      seen <= 1'b1;
      if (seen && spacing > period) period <= spacing;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bitstream_capture.sv
module bitstream_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_W       = 7,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic [2:0]       mode,
  input  logic             sync_clk_sel,
  input  logic             sync_dat_sel,
  input  logic [GAP_W-1:0] manch_thr,
  input  logic [CNT_W-1:0] wdog_limit,
  input  logic             fail_ie,
  input  logic             fail_clr,
  input  logic             mod_clk,
  input  logic             mod_dat,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic [CNT_W-1:0] period,
  output logic             fail_flag,
  output logic             fail_irq
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pin_raw, pin_sel, pin_s;
  logic             strobe, cap_bit, any_edge, halt;

  assign pin_raw = {mod_dat, mod_clk};
  assign pin_sel = {sync_dat_sel, sync_clk_sel};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    sdcap_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .raw(pin_raw[g]),
      .use_sync(pin_sel[g]), .pin(pin_s[g])
    );
  end

  sdcap_edge_qual #(.GAP_W(GAP_W), .CNT_W(CNT_W)) i_qual (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .mode(mode),
    .clk_s(pin_s[0]), .dat_s(pin_s[1]), .manch_thr(manch_thr),
    .strobe(strobe), .bit_o(cap_bit), .any_edge(any_edge)
  );

  sdcap_spacing_mon #(.CNT_W(CNT_W)) i_mon (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .edge_i(any_edge),
    .wdog_lim(wdog_limit), .period(period), .halt(halt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (strobe) begin
      out_valid <= 1'b1;
      out_bit   <= cap_bit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail_flag <= 1'b0;
    else if (halt)     fail_flag <= 1'b1;
    else if (fail_clr) fail_flag <= 1'b0;
  end

  assign fail_irq = fail_flag & fail_ie;
endmodule

// File: rtl/sdcap_checker.sv
module sdcap_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic [2:0]       mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] period,
  input logic             fail_flag,
  input logic             fail_clr
);
  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R4
  undef_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && (mode[2:1] == 2'b11) && !out_valid |=> !out_valid);

  // R6
  period_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && $past(chan_en) |-> period >= $past(period));

  // R9
  period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> period == '0);

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag && !fail_clr |=> fail_flag);
endmodule

bind bitstream_capture sdcap_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode(mode),
  .out_valid(out_valid), .out_ready(out_ready), .period(period),
  .fail_flag(fail_flag), .fail_clr(fail_clr)
);

// File: tb/test_bitstream_capture.sv
module test_bitstream_capture;
  localparam logic [11:0] EVP = 12'b1011_0010_1101;
  localparam logic [9:0]  MBITS = 10'b1100_0101_10;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 1'b0, sync_clk_sel = 1'b0, sync_dat_sel = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [6:0] manch_thr = 7'd6;
  logic [7:0] wdog_limit = 8'd20;
  logic fail_ie = 1'b0, fail_clr = 1'b0;
  logic mod_clk = 1'b0, mod_dat = 1'b0, out_ready = 1'b1;
  logic out_valid, out_bit, fail_flag, fail_irq;
  logic [7:0] period;

  int n_chk = 0, n_fail = 0;
  int got_n = 0, got_w = 0;

  always #5 clk = ~clk;

  bitstream_capture i_bitstream_capture (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode(mode),
    .sync_clk_sel(sync_clk_sel), .sync_dat_sel(sync_dat_sel),
    .manch_thr(manch_thr), .wdog_limit(wdog_limit), .fail_ie(fail_ie),
    .fail_clr(fail_clr), .mod_clk(mod_clk), .mod_dat(mod_dat),
    .out_ready(out_ready), .out_valid(out_valid), .out_bit(out_bit),
    .period(period), .fail_flag(fail_flag), .fail_irq(fail_irq)
  );

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      got_w = (got_w << 1) | int'(out_bit);
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [2:0] md, input logic sc, input logic sd, input logic idle_dat);
    @(negedge clk);
    chan_en = 1'b0; mode = md; sync_clk_sel = sc; sync_dat_sel = sd;
    mod_clk = 1'b0; mod_dat = idle_dat;
    repeat (4) @(negedge clk);
    got_n = 0; got_w = 0;
    chan_en = 1'b1;
  endtask

  task automatic drive_events(input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      @(negedge clk) mod_dat = EVP[i % 12];
      @(negedge clk) mod_clk = ~mod_clk;
      repeat (H - 2) @(negedge clk);
    end
  endtask

  task automatic run_edges(input logic [2:0] md, input logic sc, input logic sd,
                           input int first, input int step, input string req);
    int exp_w = 0, exp_n = 0;
    setup(md, sc, sd, 1'b0);
    drive_events(0, 12);
    repeat (6) @(negedge clk);
    for (int i = first; i < 12; i += step) begin
      exp_w = (exp_w << 1) | int'(EVP[i]);
      exp_n++;
    end
    chk(got_n == exp_n, req, got_n, exp_n);
    chk(got_w == exp_w, req, got_w, exp_w);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R11", int'(out_valid), 0);
    chk(period == 8'd0, "R11", int'(period), 0);
    chk(fail_flag == 1'b0, "R11", int'(fail_flag), 0);
  endtask

  task automatic t_period_and_disable;
    run_edges(3'b000, 1'b0, 1'b0, 0, 2, "R1 rise");
    chk(period == 8'd4, "R6 clock spacing", int'(period), 4);
    chk(fail_flag == 1'b0, "R7 no halt while running", int'(fail_flag), 0);
    @(negedge clk) chan_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(period == 8'd0, "R9 period cleared", int'(period), 0);
    got_n = 0;
    drive_events(0, 4);
    repeat (4) @(negedge clk);
    chk(got_n == 0, "R9 no samples while disabled", got_n, 0);
  endtask

  task automatic t_manchester;
    setup(3'b010, 1'b0, 1'b1, ~MBITS[9]);
    for (int i = 9; i >= 0; i--) begin
      mod_dat = ~MBITS[i];
      repeat (4) @(negedge clk);
      mod_dat = MBITS[i];
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk(got_n == 10, "R3 count", got_n, 10);
    chk(got_w == int'(MBITS), "R3 bits", got_w, int'(MBITS));
    chk(period == 8'd8, "R6 manchester period", int'(period), 8);
  endtask

  task automatic t_backpressure;
    setup(3'b000, 1'b0, 1'b0, 1'b0);
    out_ready = 1'b0;
    drive_events(0, 6);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b1, "R10 held valid", int'(out_valid), 1);
    chk(out_bit == EVP[4], "R10 newest kept", int'(out_bit), int'(EVP[4]));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R10 still held", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 drained", int'(out_valid), 0);
  endtask

  task automatic t_watchdog;
    setup(3'b000, 1'b0, 1'b0, 1'b0);
    wdog_limit = 8'd10; fail_ie = 1'b0;
    drive_events(0, 6);
    chk(fail_flag == 1'b0, "R7 running", int'(fail_flag), 0);
    repeat (20) @(negedge clk);
    chk(fail_flag == 1'b1, "R7 halt detected", int'(fail_flag), 1);
    chk(fail_irq == 1'b0, "R8 irq masked", int'(fail_irq), 0);
    fail_ie = 1'b1;
    @(negedge clk);
    chk(fail_irq == 1'b1, "R8 irq enabled", int'(fail_irq), 1);
    fail_clr = 1'b1;
    @(negedge clk) fail_clr = 1'b0;
    @(negedge clk);
    chk(fail_flag == 1'b1, "R8 halt beats clear", int'(fail_flag), 1);
    drive_events(0, 2);
    fail_clr = 1'b1;
    @(negedge clk) fail_clr = 1'b0;
    drive_events(2, 2);
    chk(fail_flag == 1'b0, "R8 cleared", int'(fail_flag), 0);
    wdog_limit = 8'd0;
    repeat (30) @(negedge clk);
    chk(fail_flag == 1'b0, "R7 zero limit disables", int'(fail_flag), 0);
    chan_en = 1'b0; wdog_limit = 8'd20; fail_ie = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period_and_disable();
    run_edges(3'b011, 1'b0, 1'b0, 1, 2, "R1 fall");
    run_edges(3'b001, 1'b0, 1'b0, 0, 1, "R1 both");
    run_edges(3'b100, 1'b0, 1'b0, 0, 4, "R2 alt rise");
    run_edges(3'b101, 1'b0, 1'b0, 1, 4, "R2 alt fall");
    run_edges(3'b110, 1'b0, 1'b0, 12, 1, "R4 code 110");
    run_edges(3'b111, 1'b0, 1'b0, 12, 1, "R4 code 111");
    run_edges(3'b000, 1'b1, 1'b1, 0, 2, "R5 both synced");
    run_edges(3'b001, 1'b1, 1'b0, 0, 1, "R5 clock synced");
    t_manchester();
    t_backpressure();
    t_watchdog();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule